// File: doc/BRIEF.md
# TLB Replacement State Unit

This block keeps the replacement bookkeeping for a two-level address translation cache. The small instruction-side table has four entries. Its age order is kept as a 6-bit pairwise-ordering vector: each bit records which entry of one pair of entries was used more recently. A hit strobe with the hit entry index updates the vector. A combinational decoder turns the vector into the index of the entry to evict next. A vector that fits none of the four eviction patterns raises an error flag and names entry 0.

The large unified table uses a 6-bit rotating replacement pointer. The pointer advances on every access strobe. It returns to zero when the advanced value equals a programmable limit, or when it equals the last entry number. Software can load the ordering vector, the pointer and the limit in one write, using the same packed 32-bit control word the block presents on its output. The tables and the lookup logic sit outside this block.

Top module: `tlb_repl_state`

## Requirements
- R1: After reset the ordering vector, the pointer and the limit are all zero, so `ctrl_word` reads 0.
- R2: A hit on entry 0 clears vector bits 5, 4 and 3 and leaves bits 2..0 unchanged.
- R3: A hit on entry 1 sets vector bit 5, clears bits 2 and 1, and leaves bits 4, 3 and 0 unchanged.
- R4: A hit on entry 2 sets vector bits 4 and 2, clears bit 0, and leaves bits 5, 3 and 1 unchanged.
- R5: A hit on entry 3 sets vector bits 3, 1 and 0 and leaves bits 5, 4 and 2 unchanged.
- R6: `victim_idx` is 0 when vector bits 5, 4 and 3 are all 1. Otherwise it is 1 when bit 5 is 0 and bits 2 and 1 are 1. Otherwise it is 2 when bits 4 and 2 are 0 and bit 0 is 1. Otherwise it is 3 when bits 3, 1 and 0 are all 0. The first rule in this order that matches decides, and it decides in the same cycle as the vector.
- R7: When no rule of R6 matches, `err_lru` is 1 and `victim_idx` is 0; otherwise `err_lru` is 0.
- R8: An access strobe loads the pointer with its value plus one. If that value equals the limit, the pointer becomes 0 instead.
- R9: If the incremented pointer value equals 63, the pointer becomes 0. The pointer never holds 63 after an increment.
- R10: A software write loads the vector from bits 31:26, the limit from bits 23:18 and the pointer from bits 15:10 of `sw_data`. The write wins over a hit and over an access in the same cycle.
- R11: With no hit, no access and no write, the vector, the pointer and the limit hold their values.
- R12: `ctrl_word` presents the vector in bits 31:26, the limit in bits 23:18 and the pointer in bits 15:10, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Instruction-table hit strobe |
| hit_way | input | 2 | Index of the entry that hit |
| access_strobe | input | 1 | Unified-table access, advances the pointer |
| sw_wr | input | 1 | Software write of the control word |
| sw_data | input | 32 | Control word to load |
| victim_idx | output | 2 | Entry to replace next in the instruction table |
| err_lru | output | 1 | Ordering vector matches no eviction rule |
| ctrl_word | output | 32 | Packed vector, limit and pointer |

## Verification
Random software writes place arbitrary vectors in the ordering state, including vectors that match no eviction rule, so the error path and the priority among the rules are both reached. Random hits on all four entries, starting from those vectors, separate each entry's set and clear pattern from the bits it must leave alone. Directed pointer runs approach a small limit, a limit of zero and the value 63. These runs separate the wrap at the limit from the wrap at the last entry, and a write issued together with a hit and an access shows that the write takes precedence.

// File: rtl/tlbrs_pkg.sv
package tlbrs_pkg;

    localparam int PLRU_W   = 6;
    localparam int NUM_WAYS = 4;
    localparam int WAY_W    = $clog2(NUM_WAYS);

    // Bits forced low by a hit on a given entry
    function automatic logic [PLRU_W-1:0] hit_clr_mask(input logic [WAY_W-1:0] w);
        logic [PLRU_W-1:0] m;
        case (w)
            2'd0:    m = 6'b111000;
            2'd1:    m = 6'b000110;
            2'd2:    m = 6'b000001;
            default: m = 6'b000000;
        endcase
        return m;
    endfunction

    // Bits forced high by a hit on a given entry
    function automatic logic [PLRU_W-1:0] hit_set_mask(input logic [WAY_W-1:0] w);
        logic [PLRU_W-1:0] m;
        case (w)
            2'd0:    m = 6'b000000;
            2'd1:    m = 6'b100000;
            2'd2:    m = 6'b010100;
            default: m = 6'b001011;
        endcase
        return m;
    endfunction

    // Bits that take part in the eviction rule of one entry
    function automatic logic [PLRU_W-1:0] rule_care(input int w);
        logic [PLRU_W-1:0] m;
        case (w)
            0:       m = 6'b111000;
            1:       m = 6'b100110;
            2:       m = 6'b010101;
            default: m = 6'b001011;
        endcase
        return m;
    endfunction

    // Required values of the cared-for bits
    function automatic logic [PLRU_W-1:0] rule_value(input int w);
        logic [PLRU_W-1:0] m;
        case (w)
            0:       m = 6'b111000;
            1:       m = 6'b000110;
            2:       m = 6'b000001;
            default: m = 6'b000000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tlbrs_plru_state.sv
module tlbrs_plru_state
    import tlbrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_valid,
    input  logic [WAY_W-1:0]  hit_way,
    input  logic              ld_en,
    input  logic [PLRU_W-1:0] ld_bits,
    output logic [PLRU_W-1:0] bits_q
);

    typedef struct packed {
        logic [PLRU_W-1:0] bits;
    } plru_st_t;

    plru_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_en) begin
            st_d.bits = ld_bits;
        end else if (hit_valid) begin
            st_d.bits = (st_q.bits & ~hit_clr_mask(hit_way)) | hit_set_mask(hit_way);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits_q = st_q.bits;

    a_r2_hit0: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !ld_en && hit_way == 2'd0)
        |=> (bits_q[5:3] == 3'b000 && bits_q[2:0] == $past(bits_q[2:0])));

    a_r3_hit1: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !ld_en && hit_way == 2'd1)
        |=> (bits_q[5] && !bits_q[2] && !bits_q[1]));

    a_r4_hit2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !ld_en && hit_way == 2'd2)
        |=> (bits_q[4] && bits_q[2] && !bits_q[0]));

    a_r5_hit3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !ld_en && hit_way == 2'd3)
        |=> (bits_q[3] && bits_q[1] && bits_q[0] && bits_q[5:4] == $past(bits_q[5:4])));

    a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (bits_q == $past(ld_bits)));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !hit_valid) |=> $stable(bits_q));

endmodule

// File: rtl/tlbrs_victim_dec.sv
module tlbrs_victim_dec
    import tlbrs_pkg::*;
(
    input  logic [PLRU_W-1:0] bits,
    output logic [WAY_W-1:0]  victim,
    output logic              err
);

    logic [NUM_WAYS-1:0] rule_hit;

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_rule
        assign rule_hit[g] = ((bits & rule_care(g)) == rule_value(g));
    end

    // Lowest-numbered matching rule wins
    always_comb begin
        victim = '0;
        err    = 1'b1;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (rule_hit[i]) begin
                victim = WAY_W'(i);
                err    = 1'b0;
            end
        end
    end

endmodule

// File: rtl/tlbrs_rr_counter.sv
module tlbrs_rr_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_cnt,
    input  logic [CNT_W-1:0] ld_bound,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] bound_q
);

    localparam logic [CNT_W-1:0] LAST_IDX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] bound;
    } rr_st_t;

    rr_st_t st_d, st_q;
    logic [CNT_W-1:0] bumped;

    always_comb begin
        st_d   = st_q;
        bumped = st_q.cnt + 1'b1;
        if (ld_en) begin
            st_d.cnt   = ld_cnt;
            st_d.bound = ld_bound;
        end else if (step) begin
            if (bumped == st_q.bound || bumped == LAST_IDX) st_d.cnt = '0;
            else                                            st_d.cnt = bumped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q   = st_q.cnt;
    assign bound_q = st_q.bound;

    a_r8_wrap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_en && CNT_W'(cnt_q + 1'b1) == bound_q) |=> (cnt_q == '0));

    a_r9_never_last: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_en) |=> (cnt_q != LAST_IDX));

    a_r8_bound_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> $stable(bound_q));

    a_r11_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !step) |=> $stable(cnt_q));

endmodule

// File: rtl/tlb_repl_state.sv
module tlb_repl_state
    import tlbrs_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int CTRL_W    = 32,
    parameter int LRU_LSB   = 26,
    parameter int BOUND_LSB = 18,
    parameter int CNT_LSB   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_valid,
    input  logic [1:0]        hit_way,
    input  logic              access_strobe,
    input  logic              sw_wr,
    input  logic [31:0]       sw_data,
    output logic [1:0]        victim_idx,
    output logic              err_lru,
    output logic [31:0]       ctrl_word
);

    logic [PLRU_W-1:0] lru_bits;
    logic [CNT_W-1:0]  rr_cnt;
    logic [CNT_W-1:0]  rr_bound;

    tlbrs_plru_state u_plru (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_valid (hit_valid),
        .hit_way   (hit_way),
        .ld_en     (sw_wr),
        .ld_bits   (sw_data[LRU_LSB +: PLRU_W]),
        .bits_q    (lru_bits)
    );

    tlbrs_victim_dec u_vdec (
        .bits   (lru_bits),
        .victim (victim_idx),
        .err    (err_lru)
    );

    tlbrs_rr_counter #(.CNT_W(CNT_W)) u_rr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (access_strobe),
        .ld_en    (sw_wr),
        .ld_cnt   (sw_data[CNT_LSB +: CNT_W]),
        .ld_bound (sw_data[BOUND_LSB +: CNT_W]),
        .cnt_q    (rr_cnt),
        .bound_q  (rr_bound)
    );

    always_comb begin
        ctrl_word = '0;
        ctrl_word[LRU_LSB   +: PLRU_W] = lru_bits;
        ctrl_word[BOUND_LSB +: CNT_W]  = rr_bound;
        ctrl_word[CNT_LSB   +: CNT_W]  = rr_cnt;
    end

    a_r7_err_picks0: assert property (@(posedge clk) disable iff (!rst_n)
        err_lru |-> (victim_idx == 2'd0));

    a_r6_first_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[31:29] == 3'b111) |-> (victim_idx == 2'd0 && !err_lru));

    a_r10_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> (ctrl_word[15:10] == $past(sw_data[15:10])
                   && ctrl_word[23:18] == $past(sw_data[23:18])));

    a_r12_zero_gaps: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[25:24] == 2'b00 && ctrl_word[17:16] == 2'b00 && ctrl_word[9:0] == 10'd0));

endmodule

// File: tb/test_tlb_repl_state.sv
module test_tlb_repl_state;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hit_valid;
    logic [1:0]  hit_way;
    logic        access_strobe;
    logic        sw_wr;
    logic [31:0] sw_data;
    logic [1:0]  victim_idx;
    logic        err_lru;
    logic [31:0] ctrl_word;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    logic [5:0] m_lru;
    logic [5:0] m_cnt;
    logic [5:0] m_bnd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_repl_state i_tlb_repl_state (
        .clk           (clk),
        .rst_n         (rst_n),
        .hit_valid     (hit_valid),
        .hit_way       (hit_way),
        .access_strobe (access_strobe),
        .sw_wr         (sw_wr),
        .sw_data       (sw_data),
        .victim_idx    (victim_idx),
        .err_lru       (err_lru),
        .ctrl_word     (ctrl_word)
    );

    function automatic logic [5:0] f_hit(input logic [5:0] l, input logic [1:0] w);
        logic [5:0] r;
        r = l;
        case (w)
            2'd0: begin r[5] = 0; r[4] = 0; r[3] = 0; end
            2'd1: begin r[5] = 1; r[2] = 0; r[1] = 0; end
            2'd2: begin r[4] = 1; r[2] = 1; r[0] = 0; end
            default: begin r[3] = 1; r[1] = 1; r[0] = 1; end
        endcase
        return r;
    endfunction

    // returns {err, victim}
    function automatic logic [2:0] f_victim(input logic [5:0] l);
        if (l[5] && l[4] && l[3])        return 3'b000;
        if (!l[5] && l[2] && l[1])       return 3'b001;
        if (!l[4] && !l[2] && l[0])      return 3'b010;
        if (!l[3] && !l[1] && !l[0])     return 3'b011;
        return 3'b100;
    endfunction

    function automatic logic [5:0] f_step(input logic [5:0] c, input logic [5:0] b);
        logic [5:0] n;
        n = c + 6'd1;
        if (n == b || n == 6'd63) n = 6'd0;
        return n;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_outputs(input string lru_tag, input string cnt_tag);
        logic [2:0] v;
        v = f_victim(m_lru);
        check(lru_tag, 32'(ctrl_word[31:26]), 32'(m_lru));
        check(cnt_tag, 32'(ctrl_word[15:10]), 32'(m_cnt));
        check(sw_wr ? "R10 limit" : "R8 limit", 32'(ctrl_word[23:18]), 32'(m_bnd));
        check("R12 gaps", 32'({ctrl_word[25:24], ctrl_word[17:16], ctrl_word[9:0]}), 32'd0);
        check(v[2] ? "R7 victim/err" : "R6 victim/err", 32'({err_lru, victim_idx}), 32'(v));
    endtask

    // Drive one cycle at a falling edge, update the model, check at the next falling edge
    task automatic step(input bit hv, input logic [1:0] hw, input bit acc,
                        input bit sw, input logic [31:0] data);
        string lt, ct;
        logic [5:0] nl, nc, nb;
        hit_valid = hv; hit_way = hw; access_strobe = acc; sw_wr = sw; sw_data = data;
        nl = m_lru; nc = m_cnt; nb = m_bnd;
        lt = "R11 vector hold"; ct = "R11 pointer hold";
        if (sw) begin
            nl = data[31:26]; nb = data[23:18]; nc = data[15:10];
            lt = "R10 vector load"; ct = "R10 pointer load";
        end else begin
            if (hv) begin
                nl = f_hit(m_lru, hw);
                case (hw)
                    2'd0: lt = "R2 hit0";
                    2'd1: lt = "R3 hit1";
                    2'd2: lt = "R4 hit2";
                    default: lt = "R5 hit3";
                endcase
            end
            if (acc) begin
                nc = f_step(m_cnt, m_bnd);
                ct = (m_cnt + 6'd1 == 6'd63) ? "R9 wrap at last" : "R8 advance/limit";
            end
        end
        @(negedge clk);
        m_lru = nl; m_cnt = nc; m_bnd = nb;
        check_outputs(lt, ct);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                failures++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 0; hit_valid = 0; hit_way = 0; access_strobe = 0; sw_wr = 0; sw_data = 0;
        m_lru = 0; m_cnt = 0; m_bnd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state, vector 0 gives victim 3
        check("R1 reset word", ctrl_word, 32'd0);
        check("R1 reset victim", 32'({err_lru, victim_idx}), 32'd3);

        // R2..R5 directed from all-ones and all-zeros
        step(0, 0, 0, 1, 32'hFC00_0000);
        step(1, 2'd0, 0, 0, 0);
        step(0, 0, 0, 1, 32'hFC00_0000);
        step(1, 2'd1, 0, 0, 0);
        step(0, 0, 0, 1, 32'h0000_0000);
        step(1, 2'd2, 0, 0, 0);
        step(1, 2'd3, 0, 0, 0);
        // R7: vector 010010 matches no rule
        step(0, 0, 0, 1, {6'b010010, 26'd0});
        step(0, 0, 0, 0, 0);
        // R8: limit 5, pointer 3
        step(0, 0, 0, 1, {6'd0, 2'd0, 6'd5, 2'd0, 6'd3, 10'd0});
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        // R9: limit 0, pointer 61
        step(0, 0, 0, 1, {6'd0, 2'd0, 6'd0, 2'd0, 6'd61, 10'd0});
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        // R9: pointer loaded at 63 with limit 10
        step(0, 0, 0, 1, {6'd0, 2'd0, 6'd10, 2'd0, 6'd63, 10'd0});
        step(0, 0, 1, 0, 0);
        // R10: write together with hit and access
        step(1, 2'd3, 1, 1, {6'b110100, 2'd0, 6'd9, 2'd0, 6'd7, 10'd0});
        // R11: idle
        step(0, 0, 0, 0, 32'hFFFF_FFFF);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            bit hv, acc, sw;
            logic [1:0] hw;
            logic [31:0] d;
            hv  = ($urandom_range(0, 2) != 0);
            hw  = 2'($urandom_range(0, 3));
            acc = ($urandom_range(0, 1) != 0);
            sw  = ($urandom_range(0, 9) == 0);
            d   = $urandom;
            if ($urandom_range(0, 3) == 0) d[23:18] = 6'($urandom_range(0, 7));
            step(hv, hw, acc, sw, d);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule